// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This controller decides when a data converter performs its self-calibration and reports that a calibration is under way. After the power-on reset is released it waits out a settling delay and then starts a calibration on its own. One of two delay lengths is chosen by a select input. A power-down input freezes that delay for as long as it is high, so the power-up calibration waits until the device is awake.

A user starts further calibrations through a command pin. The pin must first stay low for a minimum number of clock cycles and then stay high for another minimum number. Intervals that are too short are discarded. If the command pin is already high when reset is released, the automatic calibration is skipped and the sequencer waits for a command. Power-down blocks every start and aborts a calibration that is in progress.

The trim work itself is modelled as a busy interval of fixed length. During that interval the sequencer raises a running flag, a clock-halt enable and a data-invalid flag.

Top module: `selfcal_seq`

## Requirements
- R1: While `rstN` is low, `calBusy`, `clkHalt` and `dataInvalid` are all 0.
- R2: With `delaySel`=0, `pwrDown`=0 and `calCmd` low on the first rising edge after reset release, `calBusy` is first high after rising edge number DELAY_SHORT+1 (edge 1 is the first rising edge with `rstN` high).
- R3: With `delaySel`=1, the same start happens after edge DELAY_LONG+1.
- R4: Each rising edge from edge 2 onward that samples `pwrDown` high postpones the power-up start by one edge. The delay counter is frozen, not restarted.
- R5: Every calibration that is not aborted keeps `calBusy` high for exactly CAL_LEN consecutive rising edges. `clkHalt` and `dataInvalid` equal `calBusy` at all times.
- R6: `calCmd` sampled low on at least LOW_MIN consecutive edges and then high on HIGH_MIN consecutive edges is a valid command. `calBusy` is high after the edge that follows the edge sampling the HIGH_MIN-th high level.
- R7: A low run shorter than LOW_MIN, followed by any number of high samples, starts nothing.
- R8: A high run shorter than HIGH_MIN, after a qualified low run, starts nothing. Qualification must then begin again from a fresh low run.
- R9: If `calCmd` is high on edge 1, no power-up calibration runs. A later valid command still starts one.
- R10: A command that completes while `pwrDown` is high is dropped. Leaving power-down afterwards does not start a calibration.
- R11: `pwrDown` sampled high during a calibration clears `calBusy` after that edge. The later exit from power-down starts nothing.
- R12: A command that completes while a calibration runs is ignored. That calibration keeps its full length and no second one follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rstN | input | 1 | Active-low power-on reset |
| pwrDown | input | 1 | Power-down request, active high |
| delaySel | input | 1 | 0 = short, 1 = long power-up settling delay |
| calCmd | input | 1 | Calibration command pin (low-then-high pattern) |
| calBusy | output | 1 | High while a calibration runs |
| clkHalt | output | 1 | Enable for halting on-chip and output clocks |
| dataInvalid | output | 1 | Data and range outputs are not valid |

## Verification
Two pairs of functions can land on the same cycle. In the first, a command pattern completes while a calibration is already counting. The bench provokes it by sending two back-to-back patterns, so the second finishes inside the busy window of the first. It is judged by exactly one rising edge of `calBusy` and an unchanged run length. In the second, power-down meets a running calibration or a pending command. The bench raises `pwrDown` mid-calibration and sends a full command under power-down. It then expects `calBusy` low after the very next edge and no start at all after `pwrDown` falls.

// File: rtl/selfcal_pkg.sv
package selfcal_pkg;

  typedef enum logic [1:0] {
    ST_CHECK = 2'd0,
    ST_DELAY = 2'd1,
    ST_IDLE  = 2'd2,
    ST_CAL   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic dlyClr;
    logic dlyRun;
    logic calClr;
    logic calRun;
  } seqStrobe_t;

endpackage

// File: rtl/selfcal_cmdqual.sv
module selfcal_cmdqual #(
  parameter int LOW_MIN  = 3,
  parameter int HIGH_MIN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic calCmd,
  output logic cmdFire
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);

  logic [LW-1:0] lowCnt;
  logic [HW-1:0] highCnt;
  logic          armed;
  logic [HW-1:0] nextHigh;

  always_comb begin
    if (armed)
      nextHigh = highCnt + HW'(1);
    else if (lowCnt >= LW'(LOW_MIN))
      nextHigh = HW'(1);
    else
      nextHigh = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
      armed   <= 1'b0;
      cmdFire <= 1'b0;
    end else if (!calCmd) begin
      if (lowCnt != LW'(LOW_MIN)) lowCnt <= lowCnt + LW'(1);
      highCnt <= '0;
      armed   <= 1'b0;
      cmdFire <= 1'b0;
    end else begin
      lowCnt <= '0;
      if (nextHigh == HW'(HIGH_MIN)) begin
        cmdFire <= 1'b1;
        armed   <= 1'b0;
        highCnt <= '0;
      end else begin
        cmdFire <= 1'b0;
        armed   <= (nextHigh != '0);
        highCnt <= nextHigh;
      end
    end
  end

  // R6: a qualified command yields a one-cycle pulse
  a_r6_single_fire: assert property (@(posedge clk) disable iff (!rstN)
    cmdFire |=> !cmdFire);
  // R7, R8: a pulse only ever follows a high sample of the pin
  a_r8_fire_after_high: assert property (@(posedge clk) disable iff (!rstN)
    cmdFire |-> $past(calCmd));

endmodule

// File: rtl/selfcal_timers.sv
module selfcal_timers
  import selfcal_pkg::*;
#(
  parameter int DELAY_SHORT = 20,
  parameter int DELAY_LONG  = 50,
  parameter int CAL_LEN     = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       delaySel,
  input  seqStrobe_t strb,
  output logic       dlyDone,
  output logic       calDone
);
  localparam int DMAX = (DELAY_LONG > DELAY_SHORT) ? DELAY_LONG : DELAY_SHORT;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int CW   = $clog2(CAL_LEN + 1);

  logic [DW-1:0] dlyCnt;
  logic [DW-1:0] dlyLast;
  logic [CW-1:0] calCnt;

  assign dlyLast = delaySel ? DW'(DELAY_LONG - 1) : DW'(DELAY_SHORT - 1);
  assign dlyDone = (dlyCnt >= dlyLast);
  assign calDone = (calCnt == CW'(CAL_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dlyCnt <= '0;
    else if (strb.dlyClr) dlyCnt <= '0;
    else if (strb.dlyRun) dlyCnt <= dlyCnt + DW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            calCnt <= '0;
    else if (strb.calClr) calCnt <= '0;
    else if (strb.calRun) calCnt <= calCnt + CW'(1);
  end

  // R5: the busy interval never counts past its length
  a_r5_cal_bound: assert property (@(posedge clk) disable iff (!rstN)
    calCnt <= CW'(CAL_LEN - 1));
  // R5: the counter restarts only on a fresh calibration
  a_r5_clear_once: assert property (@(posedge clk) disable iff (!rstN)
    strb.calClr |=> (calCnt == '0));

endmodule

// File: rtl/selfcal_ctrl.sv
module selfcal_ctrl
  import selfcal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  logic       calCmd,
  input  logic       cmdFire,
  input  logic       dlyDone,
  input  logic       calDone,
  output seqStrobe_t strb,
  output logic       calBusy
);
  seqState_t st, stNext;

  always_comb begin
    stNext = st;
    strb   = '0;
    unique case (st)
      ST_CHECK: begin
        strb.dlyClr = 1'b1;
        stNext = calCmd ? ST_IDLE : ST_DELAY;
      end
      ST_DELAY: begin
        if (!pwrDown) begin
          if (cmdFire || dlyDone) begin
            stNext      = ST_CAL;
            strb.calClr = 1'b1;
          end else begin
            strb.dlyRun = 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (cmdFire && !pwrDown) begin
          stNext      = ST_CAL;
          strb.calClr = 1'b1;
        end
      end
      ST_CAL: begin
        if (pwrDown || calDone) stNext = ST_IDLE;
        else                    strb.calRun = 1'b1;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_CHECK;
    else       st <= stNext;
  end

  assign calBusy = (st == ST_CAL);

  // R10, R11: power-down sampled high leaves no calibration running
  a_r11_pd_stops: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> !calBusy);
  // R2, R6: a start is caused by the delay or by a command
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calBusy) |-> ($past(cmdFire) || $past(dlyDone)));
  // R5: busy ends only on completion or power-down
  a_r5_end_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calBusy) |-> ($past(calDone) || $past(pwrDown)));

endmodule

// File: rtl/selfcal_seq.sv
module selfcal_seq
  import selfcal_pkg::*;
#(
  parameter int LOW_MIN     = 3,
  parameter int HIGH_MIN    = 3,
  parameter int DELAY_SHORT = 20,
  parameter int DELAY_LONG  = 50,
  parameter int CAL_LEN     = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrDown,
  input  logic delaySel,
  input  logic calCmd,
  output logic calBusy,
  output logic clkHalt,
  output logic dataInvalid
);
  seqStrobe_t strb;
  logic cmdFire, dlyDone, calDone, busy;

  selfcal_cmdqual #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) uQual (
    .clk(clk), .rstN(rstN), .calCmd(calCmd), .cmdFire(cmdFire));

  selfcal_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .calCmd(calCmd),
    .cmdFire(cmdFire), .dlyDone(dlyDone), .calDone(calDone),
    .strb(strb), .calBusy(busy));

  selfcal_timers #(.DELAY_SHORT(DELAY_SHORT), .DELAY_LONG(DELAY_LONG),
                   .CAL_LEN(CAL_LEN)) uTim (
    .clk(clk), .rstN(rstN), .delaySel(delaySel), .strb(strb),
    .dlyDone(dlyDone), .calDone(calDone));

  assign calBusy     = busy;
  assign clkHalt     = busy;
  assign dataInvalid = busy;

  // R1: nothing is flagged while reset holds
  always_comb a_r1_reset_quiet: assert (rstN || !busy);

endmodule

// File: tb/sim_selfcal_seq.sv
`timescale 1ns/1ps
module sim_selfcal_seq;
  localparam int LMIN = 3, HMIN = 3, DSHORT = 20, DLONG = 50, CLEN = 12;

  logic clk = 0, rstN = 0, pwrDown = 0, delaySel = 0, calCmd = 0;
  logic calBusy, clkHalt, dataInvalid;

  int nChk = 0, nBad = 0;
  int edgeNo = 0, riseCnt = 0, riseEdge = 0, runLen = 0, lastLen = 0, eqErr = 0;
  logic prevBusy = 0;
  bit finished = 0;

  selfcal_seq #(.LOW_MIN(LMIN), .HIGH_MIN(HMIN), .DELAY_SHORT(DSHORT),
                .DELAY_LONG(DLONG), .CAL_LEN(CLEN)) u0 (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .delaySel(delaySel),
    .calCmd(calCmd), .calBusy(calBusy), .clkHalt(clkHalt),
    .dataInvalid(dataInvalid));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    edgeNo++;
    #1;
    if (clkHalt !== calBusy || dataInvalid !== calBusy) eqErr++;
    if (calBusy && !prevBusy) begin riseCnt++; riseEdge = edgeNo; runLen = 1; end
    else if (calBusy) runLen++;
    else if (prevBusy) lastLen = runLen;
    prevBusy = calBusy;
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && calBusy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmdPattern(int l, int h, output int e);
    @(negedge clk);
    e = edgeNo;
    calCmd = 0;
    repeat (l) @(negedge clk);
    calCmd = 1;
    repeat (h) @(negedge clk);
    calCmd = 0;
    @(negedge clk);
    calCmd = 1;
  endtask

  task automatic powerUp(int sel, int p, string req);
    int e0;
    rstN = 0; delaySel = sel[0]; pwrDown = (p > 0); calCmd = 0;
    repeat (3) @(negedge clk);
    rstN = 1; e0 = edgeNo; riseCnt = 0;
    @(negedge clk);
    calCmd = 1;
    repeat (p) @(negedge clk);
    pwrDown = 0;
    for (int i = 0; i < DLONG + 30 && riseCnt == 0; i++) @(negedge clk);
    chk(req, riseEdge - e0, (sel ? DLONG : DSHORT) + p + 1);
    waitIdle();
    chk("R5 length", lastLen, CLEN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int e;
    // R1
    repeat (2) @(negedge clk);
    chk("R1 busy", calBusy, 0);
    chk("R1 halt", clkHalt, 0);
    chk("R1 invalid", dataInvalid, 0);

    powerUp(0, 0, "R2");
    powerUp(1, 0, "R3");
    for (int p = 1; p <= 4; p++) powerUp(0, p, "R4");
    powerUp(1, 3, "R4 long");

    // R9: pin high on edge 1 skips the automatic calibration
    rstN = 0; delaySel = 0; pwrDown = 0; calCmd = 1;
    repeat (3) @(negedge clk);
    rstN = 1; riseCnt = 0;
    repeat (DLONG + 10) @(negedge clk);
    chk("R9 no power-up cal", riseCnt, 0);

    // R6, R7, R8 sweep over low and high run lengths
    for (int l = 1; l <= 5; l++) begin
      for (int h = 1; h <= 5; h++) begin
        bit ok;
        ok = (l >= LMIN) && (h >= HMIN);
        riseCnt = 0;
        cmdPattern(l, h, e);
        repeat (4) @(negedge clk);
        if (l < LMIN)      chk("R7 short low", riseCnt, 0);
        else if (h < HMIN) chk("R8 short high", riseCnt, 0);
        else begin
          chk("R6 started", riseCnt, 1);
          chk("R6 start edge", riseEdge - e, l + HMIN + 1);
        end
        waitIdle();
        if (ok) chk("R5 length", lastLen, CLEN);
      end
    end

    // R8: after a short high the pin must requalify
    riseCnt = 0;
    cmdPattern(4, 2, e);
    calCmd = 1;
    repeat (10) @(negedge clk);
    chk("R8 requalify", riseCnt, 0);
    cmdPattern(3, 3, e);
    repeat (4) @(negedge clk);
    chk("R9 command after skip", riseCnt, 1);
    waitIdle();

    // R10: command under power-down dropped
    riseCnt = 0;
    pwrDown = 1;
    cmdPattern(4, 4, e);
    repeat (6) @(negedge clk);
    pwrDown = 0;
    repeat (20) @(negedge clk);
    chk("R10 blocked", riseCnt, 0);

    // R11: abort on power-down
    riseCnt = 0;
    cmdPattern(3, 3, e);
    for (int i = 0; i < 20 && !calBusy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    pwrDown = 1;
    @(negedge clk);
    chk("R11 abort", calBusy, 0);
    chk("R11 halt drop", clkHalt, 0);
    repeat (5) @(negedge clk);
    riseCnt = 0;
    pwrDown = 0;
    repeat (30) @(negedge clk);
    chk("R11 no restart", riseCnt, 0);

    // R12: second command overlaps a running calibration
    riseCnt = 0;
    cmdPattern(3, 3, e);
    cmdPattern(3, 3, e);
    repeat (30) @(negedge clk);
    chk("R12 single run", riseCnt, 1);
    chk("R12 full length", lastLen, CLEN);

    chk("R5 outputs track", eqErr, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule